// File: doc/BRIEF.md
# Asynchronous SRAM Page-Mode Controller

This block is a synchronous controller that connects an internal request port to an external 512K x 16 asynchronous static RAM. It drives the two chip selects, which have opposite polarity, the write strobe, the output enable, the two byte-lane enables and the 19-bit word address. It also drives the outgoing half of the split data bus and its drive enable, and it captures the incoming half.

A command has a direction flag, a word address, write data, a two-bit lane mask and a four-bit burst count. A write stores one word under its lane mask. A read returns the burst count plus one consecutive words. The first word of a read takes a full random-access cycle. Later words in the same 16-word page change only the four low address bits, so they complete in the shorter page-access time. A word that starts a new page, including the wrap from the top address to zero, takes a full random-access cycle again.

The cycle counts come from parameters: the clock period and the two access times in nanoseconds, each count rounded up. With the defaults (10 ns clock, 70 ns random access, 25 ns page access) a random access lasts 7 cycles and a page access 3 cycles.

Top module: `sram_page_ctrl`

## Requirements
- R1: `req_ready` is high only when the controller is idle. A command is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle that follows.
- R2: While idle or turning the bus around, the pins are in this state: `ram_ce1_n`=1, `ram_ce2`=0, `ram_we_n`=1, `ram_oe_n`=1 and `ram_dq_oe`=0. The same holds right after reset, with `rd_valid`=0.
- R3: During every read or write cycle the RAM is selected, with `ram_ce1_n`=0 and `ram_ce2`=1.
- R4: A write lasts RAND cycles (RAND = ceil(T_RAND_NS/CLK_NS)).
  - Address, data and lane enables stay stable for the whole write, and data is driven for the whole write.
  - `ram_we_n` is low for the first RAND-1 cycles and high in the last cycle, while the address is still held.
  - Mask bit 0 enables data bits 7:0 through `ram_lb_n`=0. Mask bit 1 enables bits 15:8 through `ram_ub_n`=0.
- R5: `ram_dq_oe` is never high while `ram_oe_n` is low. After a write there is one cycle with the RAM deselected and the data driver off. `req_ready` returns RAND+1 cycles after the write was accepted.
- R6: During a read, the pins are `ram_we_n`=1, `ram_oe_n`=0 and both lane enables low, whatever the lane mask. The first word's `rd_valid` pulse comes RAND cycles after the accepting edge.
- R7: When the next word lies in the same page, only address bits 3:0 change, by +1. Its `rd_valid` pulse follows the previous one by PAGE cycles (PAGE = ceil(T_PAGE_NS/CLK_NS)).
- R8: When the next word starts a new page (address bits 3:0 of the previous word are 15, including the wrap from 0x7FFFF to 0), the address steps by +1 modulo 2^19 and the pulse interval is RAND cycles.
- R9: A read with `req_len`=N gives exactly N+1 single-cycle `rd_valid` pulses. The words come in ascending address order and each carries the stored word. `req_ready` is high again in the cycle of the last pulse.
- R10: A write with lane mask 00 keeps both `ram_ub_n` and `ram_lb_n` high for the whole write, which leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Command valid |
| req_ready | output | 1 | Controller idle, command can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Lane mask for writes (bit 0 = low byte) |
| req_len | input | 4 | Read burst length minus one |
| rd_valid | output | 1 | One-cycle pulse per returned word |
| rd_data | output | 16 | Returned word |
| ram_addr | output | 19 | RAM word address |
| ram_ce1_n | output | 1 | Chip select, active low |
| ram_ce2 | output | 1 | Chip select, active high |
| ram_we_n | output | 1 | Write strobe, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_ub_n | output | 1 | Upper lane enable (bits 15:8), active low |
| ram_lb_n | output | 1 | Lower lane enable (bits 7:0), active low |
| ram_dq_out | output | 16 | Data toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for `ram_dq_out` |
| ram_dq_in | input | 16 | Data from the RAM |

## Verification
Several pin rules are checked on every cycle:
- the handshake;
- the idle pin state;
- the absence of data drive while the output enable is low;
- the deselected cycle after a write;
- the stability of address, data and lanes during a write;
- the write strobe rising while the address is still held;
- the rule that addresses advance by exactly one within a read burst.

The exact access latencies cannot be judged from the pins alone, so only the bench scenarios show them. The bench models a RAM whose output is valid only after the random or page access time. These scenarios also show the page-boundary fallback, the wrap at the top address, lane-masked and empty-mask writes, and the order and count of returned words.

// File: rtl/sram_pm_pkg.sv
package sram_pm_pkg;

    localparam int ADDR_W    = 19;
    localparam int DATA_W    = 16;
    localparam int LANE_W    = 8;
    localparam int LANES     = DATA_W / LANE_W;
    localparam int WORD_BITS = 4;
    localparam int LEN_W     = WORD_BITS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_RAND,
        ST_RD_PAGE,
        ST_WR,
        ST_TURN
    } ctl_state_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  lanes;
        logic [LEN_W-1:0]  len;
    } sram_cmd_t;

    typedef struct packed {
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  lanes;
    } wr_hold_t;

    typedef struct packed {
        logic             ce1_n;
        logic             ce2;
        logic             we_n;
        logic             oe_n;
        logic [LANES-1:0] lane_n;
        logic             dq_oe;
    } sram_pins_t;

    // Round an access time up to whole clock cycles, minimum one.
    function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sram_burst_tracker.sv
module sram_burst_tracker #(
    parameter int ADDR_W    = 19,
    parameter int WORD_BITS = 4,
    parameter int LEN_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last,
    output logic              page_end
);
    logic [LEN_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            remain <= '0;
        end else if (start) begin
            addr   <= start_addr;
            remain <= start_len;
        end else if (step) begin
            addr   <= addr + 1'b1;
            remain <= remain - 1'b1;
        end
    end

    assign last     = (remain == '0);
    assign page_end = &addr[WORD_BITS-1:0];
endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
    import sram_pm_pkg::*;
(
    input  ctl_state_e       state,
    input  logic             expired,
    input  logic [LANES-1:0] lanes,
    output sram_pins_t       pins
);
    logic reading;
    logic writing;
    logic [LANES-1:0] lane_n;

    assign reading = (state == ST_RD_RAND) || (state == ST_RD_PAGE);
    assign writing = (state == ST_WR);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_n[g] = ~(reading | (writing & lanes[g]));
    end

    always_comb begin
        pins.ce1_n  = ~(reading | writing);
        pins.ce2    = reading | writing;
        pins.we_n   = ~(writing & ~expired);
        pins.oe_n   = ~reading;
        pins.lane_n = lane_n;
        pins.dq_oe  = writing;
    end
endmodule

// File: rtl/sram_page_ctrl.sv
module sram_page_ctrl
    import sram_pm_pkg::*;
#(
    parameter int CLK_NS    = 10,
    parameter int T_RAND_NS = 70,
    parameter int T_PAGE_NS = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_bmask,
    input  logic [LEN_W-1:0]  req_len,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_ce1_n,
    output logic              ram_ce2,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic              ram_ub_n,
    output logic              ram_lb_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);
    localparam int RAND_CYC = ns_to_cycles(T_RAND_NS, CLK_NS);
    localparam int PAGE_CYC = ns_to_cycles(T_PAGE_NS, CLK_NS);
    localparam int MAX_CYC  = (RAND_CYC > PAGE_CYC) ? RAND_CYC : PAGE_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RAND_LOAD = CNT_W'(RAND_CYC - 1);
    localparam logic [CNT_W-1:0] PAGE_LOAD = CNT_W'(PAGE_CYC - 1);

    ctl_state_e state;
    sram_cmd_t  req_cmd;
    wr_hold_t   wr_q;
    sram_pins_t pins;

    logic expired, last, page_end;
    logic reading, accept, step, tmr_load;
    logic [CNT_W-1:0] tmr_val;

    assign req_cmd = '{write: req_write, addr: req_addr, wdata: req_wdata,
                       lanes: req_bmask, len: req_len};

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign reading   = (state == ST_RD_RAND) || (state == ST_RD_PAGE);
    assign step      = reading && expired && !last;
    assign tmr_load  = accept || step;
    assign tmr_val   = (accept || page_end) ? RAND_LOAD : PAGE_LOAD;

    sram_cycle_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    sram_burst_tracker #(
        .ADDR_W    (ADDR_W),
        .WORD_BITS (WORD_BITS),
        .LEN_W     (LEN_W)
    ) i_tracker (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .start_addr (req_cmd.addr),
        .start_len  (req_cmd.len),
        .step       (step),
        .addr       (ram_addr),
        .last       (last),
        .page_end   (page_end)
    );

    sram_pin_decode i_decode (
        .state   (state),
        .expired (expired),
        .lanes   (wr_q.lanes),
        .pins    (pins)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            wr_q     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        wr_q  <= '{wdata: req_cmd.wdata, lanes: req_cmd.lanes};
                        state <= req_cmd.write ? ST_WR : ST_RD_RAND;
                    end
                end
                ST_RD_RAND, ST_RD_PAGE: begin
                    if (expired) begin
                        rd_valid <= 1'b1;
                        rd_data  <= ram_dq_in;
                        if (last)          state <= ST_IDLE;
                        else if (page_end) state <= ST_RD_RAND;
                        else               state <= ST_RD_PAGE;
                    end
                end
                ST_WR: begin
                    if (expired) state <= ST_TURN;
                end
                ST_TURN: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ram_ce1_n  = pins.ce1_n;
    assign ram_ce2    = pins.ce2;
    assign ram_we_n   = pins.we_n;
    assign ram_oe_n   = pins.oe_n;
    assign ram_ub_n   = pins.lane_n[1];
    assign ram_lb_n   = pins.lane_n[0];
    assign ram_dq_out = wr_q.wdata;
    assign ram_dq_oe  = pins.dq_oe;
endmodule

// File: rtl/sram_page_ctrl_checker.sv
module sram_page_ctrl_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rd_valid,
    input logic [18:0] ram_addr,
    input logic        ram_ce1_n,
    input logic        ram_ce2,
    input logic        ram_we_n,
    input logic        ram_oe_n,
    input logic        ram_ub_n,
    input logic        ram_lb_n,
    input logic [15:0] ram_dq_out,
    input logic        ram_dq_oe
);
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r2_idle_pins: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ram_ce1_n && !ram_ce2 && ram_oe_n && ram_we_n && !ram_dq_oe));

    a_r3_selected_on_write: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> (!ram_ce1_n && ram_ce2 && ram_dq_oe));

    a_r4_write_stable: assert property (@(posedge clk) disable iff (rst)
        (ram_dq_oe && $past(ram_dq_oe)) |->
            ($stable(ram_addr) && $stable(ram_dq_out) && $stable({ram_ub_n, ram_lb_n})));

    a_r4_we_rise_addr_held: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_we_n) |-> ($stable(ram_addr) && ram_dq_oe));

    a_r5_no_contention: assert property (@(posedge clk) disable iff (rst)
        ram_dq_oe |-> ram_oe_n);

    a_r5_turnaround: assert property (@(posedge clk) disable iff (rst)
        $fell(ram_dq_oe) |-> (ram_oe_n && ram_ce1_n));

    a_r7_burst_step: assert property (@(posedge clk) disable iff (rst)
        (!ram_oe_n && $past(!ram_oe_n) && (ram_addr != $past(ram_addr))) |->
            (ram_addr == 19'($past(ram_addr) + 19'd1)));

    a_r9_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!ram_oe_n));
endmodule

bind sram_page_ctrl sram_page_ctrl_checker i_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .ram_addr   (ram_addr),
    .ram_ce1_n  (ram_ce1_n),
    .ram_ce2    (ram_ce2),
    .ram_we_n   (ram_we_n),
    .ram_oe_n   (ram_oe_n),
    .ram_ub_n   (ram_ub_n),
    .ram_lb_n   (ram_lb_n),
    .ram_dq_out (ram_dq_out),
    .ram_dq_oe  (ram_dq_oe)
);

// File: tb/test_sram_page_ctrl.sv
module test_sram_page_ctrl;
    // Default timing: ceil(70/10) and ceil(25/10).
    localparam int RAND = 7;
    localparam int PAGE = 3;

    typedef struct packed {
        logic        wr;
        logic [18:0] addr;
        logic [15:0] data;
        logic [1:0]  bmask;
        logic [3:0]  len;
        logic [7:0]  exp_last;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 19'h00010, 16'h1111, 2'b11, 4'd0,  8'd8},
        '{1'b1, 19'h00011, 16'h2222, 2'b11, 4'd0,  8'd8},
        '{1'b1, 19'h00012, 16'hA5C3, 2'b01, 4'd0,  8'd8},
        '{1'b1, 19'h00013, 16'h7777, 2'b00, 4'd0,  8'd8},
        '{1'b0, 19'h00010, 16'h0000, 2'b00, 4'd3,  8'd16},
        '{1'b1, 19'h0001F, 16'hBEEF, 2'b11, 4'd0,  8'd8},
        '{1'b1, 19'h00020, 16'hCAFE, 2'b10, 4'd0,  8'd8},
        '{1'b0, 19'h0001E, 16'h0000, 2'b01, 4'd3,  8'd20},
        '{1'b1, 19'h7FFFF, 16'h5A5A, 2'b11, 4'd0,  8'd8},
        '{1'b0, 19'h7FFFF, 16'h0000, 2'b10, 4'd1,  8'd14},
        '{1'b0, 19'h00015, 16'h0000, 2'b11, 4'd0,  8'd7},
        '{1'b0, 19'h00000, 16'h0000, 2'b00, 4'd15, 8'd52}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_bmask = '0;
    logic [3:0]  req_len = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [18:0] ram_addr;
    logic        ram_ce1_n, ram_ce2, ram_we_n, ram_oe_n, ram_ub_n, ram_lb_n;
    logic [15:0] ram_dq_out;
    logic        ram_dq_oe;
    logic [15:0] ram_dq_in;

    always #2 clk = ~clk;

    sram_page_ctrl i_sram_page_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_bmask(req_bmask), .req_len(req_len), .rd_valid(rd_valid),
        .rd_data(rd_data), .ram_addr(ram_addr), .ram_ce1_n(ram_ce1_n),
        .ram_ce2(ram_ce2), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
        .ram_ub_n(ram_ub_n), .ram_lb_n(ram_lb_n), .ram_dq_out(ram_dq_out),
        .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- RAM model with access-time checking ----------------
    bit [15:0] sram_mem [int];
    bit [15:0] ref_mem  [int];
    logic      sel;
    int        page_age = 0;
    int        word_age = 0;
    logic [18:0] prev_addr = '0;

    assign sel = !ram_ce1_n && ram_ce2 && !(ram_ub_n && ram_lb_n);

    always @(negedge clk) begin
        page_age  <= (ram_addr[18:4] != prev_addr[18:4]) ? 1 : page_age + 1;
        word_age  <= (ram_addr != prev_addr) ? 1 : word_age + 1;
        prev_addr <= ram_addr;
    end

    function automatic logic [15:0] model_read(input logic [18:0] a, input logic ub_n,
                                               input logic lb_n);
        logic [15:0] w;
        w = sram_mem.exists(int'(a)) ? sram_mem[int'(a)] : 16'h0000;
        return {ub_n ? 8'h00 : w[15:8], lb_n ? 8'h00 : w[7:0]};
    endfunction

    assign ram_dq_in = (sel && ram_we_n && !ram_oe_n)
                     ? ((page_age >= RAND && word_age >= PAGE)
                        ? model_read(ram_addr, ram_ub_n, ram_lb_n) : 16'hDEAD)
                     : 16'h0000;

    always @(posedge clk) begin
        if (sel && !ram_we_n && ram_dq_oe) begin
            bit [15:0] w;
            w = sram_mem.exists(int'(ram_addr)) ? sram_mem[int'(ram_addr)] : 16'h0000;
            if (!ram_ub_n) w[15:8] = ram_dq_out[15:8];
            if (!ram_lb_n) w[7:0]  = ram_dq_out[7:0];
            sram_mem[int'(ram_addr)] = w;
        end
    end

    // ---------------- read-return monitor ----------------
    logic [15:0] got_data [32];
    int          got_cyc  [32];
    int          n_got = 0;

    always @(negedge clk) begin
        if (rd_valid && n_got < 32) begin
            got_data[n_got] = rd_data;
            got_cyc[n_got]  = cyc;
            n_got           = n_got + 1;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic [18:0] a, input logic [15:0] d,
                         input logic [1:0] bm, input logic [3:0] len, output int acc);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        n_got     = 0;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_bmask = bm;
        req_len   = len;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        acc = cyc;
    endtask

    function automatic bit [15:0] ref_word(input logic [18:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
    endfunction

    task automatic ref_write(input logic [18:0] a, input logic [15:0] d, input logic [1:0] bm);
        bit [15:0] w;
        w = ref_word(a);
        if (bm[1]) w[15:8] = d[15:8];
        if (bm[0]) w[7:0]  = d[7:0];
        ref_mem[int'(a)] = w;
    endtask

    task automatic do_write(input logic [18:0] a, input logic [15:0] d, input logic [1:0] bm,
                            input int exp_delay);
        int acc;
        issue(1'b1, a, d, bm, 4'd0, acc);
        while (!req_ready) @(negedge clk);
        check("R5", "write ready delay", cyc - acc, exp_delay);
        ref_write(a, d, bm);
    endtask

    task automatic do_read(input logic [18:0] a, input logic [3:0] len, input int exp_last);
        int acc;
        int words;
        words = int'(len) + 1;
        issue(1'b0, a, 16'h0, 2'b00, len, acc);
        for (int t = 0; t < 200 && n_got < words; t++) @(negedge clk);
        while (!req_ready) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R9", "word count", n_got, words);
        if (n_got >= 1) check("R6", "first word delay", got_cyc[0] - acc, RAND);
        if (n_got == words) check("R8", "last word delay", got_cyc[words-1] - acc, exp_last);
        for (int i = 0; i < words && i < n_got; i++) begin
            logic [18:0] wa;
            wa = a + 19'(i);
            check("R9", "word data", got_data[i], ref_word(wa));
            if (i > 0) begin
                if (wa[3:0] == 4'h0)
                    check("R8", "page-cross interval", got_cyc[i] - got_cyc[i-1], RAND);
                else
                    check("R7", "page interval", got_cyc[i] - got_cyc[i-1], PAGE);
            end
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int acc;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        check("R2", "ce1_n after reset", ram_ce1_n, 1);
        check("R2", "ce2 after reset", ram_ce2, 0);
        check("R2", "we_n/oe_n after reset", {ram_we_n, ram_oe_n}, 2'b11);
        check("R2", "dq_oe/rd_valid after reset", {ram_dq_oe, rd_valid}, 2'b00);
        check("R1", "ready after reset", req_ready, 1);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            if (VECS[v].wr)
                do_write(VECS[v].addr, VECS[v].data, VECS[v].bmask, int'(VECS[v].exp_last));
            else
                do_read(VECS[v].addr, VECS[v].len, int'(VECS[v].exp_last));
        end

        // Directed: write pin trace, upper lane only
        issue(1'b1, 19'h00100, 16'h1234, 2'b10, 4'd0, acc);
        for (int k = 0; k <= RAND + 1; k++) begin
            if (k < RAND) begin
                check("R4", "we_n in write", ram_we_n, (k == RAND - 1));
                check("R4", "addr held", ram_addr, 19'h00100);
                check("R4", "data driven", {ram_dq_oe, ram_dq_out}, {1'b1, 16'h1234});
                check("R4", "lanes ub/lb", {ram_ub_n, ram_lb_n}, 2'b01);
                check("R3", "selected in write", {ram_ce1_n, ram_ce2}, 2'b01);
                check("R1", "busy in write", req_ready, 0);
            end else if (k == RAND) begin
                check("R5", "turnaround drive off", ram_dq_oe, 0);
                check("R5", "turnaround deselect", {ram_ce1_n, ram_ce2}, 2'b10);
                check("R1", "busy in turnaround", req_ready, 0);
            end else begin
                check("R1", "ready after write", req_ready, 1);
            end
            @(negedge clk);
        end
        ref_write(19'h00100, 16'h1234, 2'b10);

        // Directed: empty-mask write keeps both lanes off and memory unchanged
        issue(1'b1, 19'h00100, 16'hFFFF, 2'b00, 4'd0, acc);
        for (int k = 0; k < RAND; k++) begin
            check("R10", "lanes off in empty write", {ram_ub_n, ram_lb_n}, 2'b11);
            @(negedge clk);
        end
        while (!req_ready) @(negedge clk);

        // Directed: read pin state, lane mask ignored
        issue(1'b0, 19'h00100, 16'h0, 2'b01, 4'd0, acc);
        check("R6", "read pins we/oe", {ram_we_n, ram_oe_n}, 2'b10);
        check("R6", "read lanes both on", {ram_ub_n, ram_lb_n}, 2'b00);
        check("R3", "selected in read", {ram_ce1_n, ram_ce2}, 2'b01);
        check("R5", "no drive in read", ram_dq_oe, 0);
        while (!req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R10", "word after empty write", got_data[0], 16'h1200);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule